// File: doc/BRIEF.md
# Serial Control Register Slave

This block is a two-wire serial slave that follows the SMBus timing. It sits in front of a small bank of 8-bit control registers. The registers hold clock output enables, spread-spectrum controls and stop-gating masks, and every register bit is driven to the rest of the chip as a parallel output. The block samples SCL and SDA with its own system clock. It pulls SDA low through a single output-enable and never drives the line high.

The first byte after the address is a command byte. When bit 7 of that byte is 1, the access is to one register, whose index is given by bits 6:0. When bit 7 is 0, the access is a counted block that always starts at register 0 and moves upward. On a block write the master sends a byte count before the data. On a block read the slave returns a byte count first. Reads are made with a repeated start followed by the read address, and they use the mode chosen by the last command byte.

Top module: `smb_ctl_regs`

## Requirements
- R1: The slave ACKs only the 7-bit address 0x69, which is 0xD2 with the write bit and 0xD3 with the read bit. After any other address it NACKs, ignores all bytes and does not drive SDA until the next start.
- R2: After reset the registers hold these values: register 0 = 0xFF, register 1 = 0xFE, register 2 = 0xFF, register 3 = 0x00.
- R3: A command byte with bit 7 = 1 selects single-register access, and bits 6:0 give the index. The next data byte is ACKed and written to that register.
- R4: A single-register read returns the selected register. An index at or above the number of implemented registers returns 0x00.
- R5: A command byte of 0x00 starts a block write. The master sends a byte count and then data bytes, which go to registers 0, 1, 2 and so on. The slave ACKs the count and every data byte.
- R6: In a block write, data bytes aimed at indexes past the last implemented register are ACKed but not stored. Any byte beyond the byte count is NACKed and not stored.
- R7: A block read returns the number of implemented registers (4) as its first byte. It then returns the registers in ascending order, and 0x00 for any index past the last implemented register.
- R8: When the master NACKs a read byte, the slave releases SDA and stays idle until the next start.
- R9: A stop or a start that arrives before the 8th bit of a byte cancels that byte and leaves every register unchanged. A transaction that follows it works normally.
- R10: The slave changes its SDA drive only after a falling SCL edge, or to release the line on a start or stop. It never changes the drive while SCL is high.
- R11: In single-register mode, a second data byte after the first is NACKed and not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | Drive SDA low when 1; release the line when 0 |
| reg_q | output | NUM_REGS*8 | Register contents; register k occupies bits 8k+7 down to 8k |

## Verification
Some properties are checked by assertions on every cycle. The SDA drive stays constant unless an SCL fall, a start or a stop came just before it. The line is released the cycle after a stop. Each register write happens right after an SCL fall and is ACKed. The registers hold their reset values in the first cycle after reset. The rest can only be shown by the bench's directed transactions. These cover address filtering, the command bit 7 split, the byte count returned and consumed, data dropped past the last register or past the count, and bytes cut short by a stop or a repeated start. The bench also counts any SDA change that it sees while SCL is high.

// File: rtl/smb_pkg.sv
`timescale 1ns/1ps
package smb_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_CMD,
    S_WDAT,
    S_ACK,
    S_TX,
    S_MACK
  } smb_state_t;

  // power-up value of each control register
  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      0:       return 8'hFF;
      1:       return 8'hFE;
      2:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_edge_det.sv
`timescale 1ns/1ps
module smb_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[SYNC_STAGES-1];
      sda_d    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_regbank.sv
`timescale 1ns/1ps
module smb_regbank
  import smb_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int PTR_W    = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [PTR_W-1:0]      waddr,
  input  logic [7:0]            wdata,
  input  logic [PTR_W-1:0]      raddr,
  output logic [7:0]            rdata,
  output logic [NUM_REGS*8-1:0] q
);

  logic [7:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= reg_default(g);
      else if (we && waddr == PTR_W'(g))
        regs[g] <= wdata;
    end
    assign q[g*8 +: 8] = regs[g];

    // R2: the first cycle after reset shows the power-up value
    p_default_r2: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> regs[g] == reg_default(g));
  end

  always_comb begin
    rdata = 8'h00;
    for (int k = 0; k < NUM_REGS; k++)
      if (raddr == PTR_W'(k)) rdata = regs[k];
  end

endmodule

// File: rtl/smb_proto.sv
`timescale 1ns/1ps
module smb_proto
  import smb_pkg::*;
#(
  parameter int         NUM_REGS = 4,
  parameter int         PTR_W    = 7,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rdata,
  output logic [PTR_W-1:0] raddr,
  output logic             we,
  output logic [PTR_W-1:0] waddr,
  output logic [7:0]       wdata,
  output logic             sda_oe
);

  localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

  smb_state_t       st, ack_next;
  logic [3:0]       cnt;
  logic [7:0]       sh, tx, left;
  logic             blk, need_count, byte_done, cnt_sent, mack;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       next_tx;
  logic             load_now;

  assign raddr   = ptr;
  assign next_tx = (blk && !cnt_sent) ? COUNT_BYTE : rdata;
  assign load_now = scl_fall && !start_det && !stop_det &&
                    ((st == S_ACK && ack_next == S_TX) || (st == S_MACK && mack));

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      ack_next   <= S_IDLE;
      cnt        <= '0;
      sh         <= '0;
      tx         <= '0;
      left       <= '0;
      blk        <= 1'b0;
      need_count <= 1'b0;
      byte_done  <= 1'b0;
      cnt_sent   <= 1'b0;
      mack       <= 1'b0;
      ptr        <= '0;
      we         <= 1'b0;
      waddr      <= '0;
      wdata      <= '0;
      sda_oe     <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start_det) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_CMD, S_WDAT: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end
            if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              st  <= S_ACK;
              if (st == S_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe   <= 1'b1;
                  ack_next <= sh[0] ? S_TX : S_CMD;
                end else begin
                  sda_oe   <= 1'b0;
                  ack_next <= S_IDLE;
                end
              end else if (st == S_CMD) begin
                blk        <= ~sh[7];
                ptr        <= sh[7] ? sh[6:0] : '0;
                need_count <= ~sh[7];
                byte_done  <= 1'b0;
                cnt_sent   <= 1'b0;
                sda_oe     <= 1'b1;
                ack_next   <= S_WDAT;
              end else if (need_count) begin
                left       <= sh;
                need_count <= 1'b0;
                sda_oe     <= 1'b1;
                ack_next   <= S_WDAT;
              end else if (blk ? (left != 8'd0) : !byte_done) begin
                we        <= ({1'b0, ptr} < {1'b0, PTR_W'(NUM_REGS)});
                waddr     <= ptr;
                wdata     <= sh;
                ptr       <= ptr + 1'b1;
                left      <= blk ? left - 8'd1 : left;
                byte_done <= 1'b1;
                sda_oe    <= 1'b1;
                ack_next  <= S_WDAT;
              end else begin
                sda_oe   <= 1'b0;
                ack_next <= S_IDLE;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= ack_next;
              cnt    <= '0;
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= S_MACK;
                cnt    <= '0;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
                cnt    <= cnt + 4'd1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall && !mack) begin
              st     <= S_IDLE;
              sda_oe <= 1'b0;
            end
          end
          default: st <= S_IDLE;
        endcase
        if (load_now) begin
          st     <= S_TX;
          tx     <= next_tx;
          sda_oe <= ~next_tx[7];
          cnt    <= '0;
          if (blk && !cnt_sent) cnt_sent <= 1'b1;
          else                  ptr      <= ptr + 1'b1;
        end
      end
    end
  end

  // R10: the drive only moves after an SCL fall, a start or a stop
  p_oe_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(scl_fall) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

  // R8: the line is free one cycle after a stop
  p_release_stop_r8: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R9: a register write follows directly on an SCL fall
  p_write_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
    we |-> $past(scl_fall));

  // R5: every stored byte is acknowledged
  p_write_acked_r5: assert property (@(posedge clk) disable iff (rst)
    we |-> sda_oe);

endmodule

// File: rtl/smb_ctl_regs.sv
`timescale 1ns/1ps
module smb_ctl_regs #(
  parameter int         NUM_REGS    = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h69
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] reg_q
);

  localparam int PTR_W = 7;

  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             we;
  logic [PTR_W-1:0] waddr, raddr;
  logic [7:0]       wdata, rdata;

  smb_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_proto #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .DEV_ADDR(DEV_ADDR)) u_proto (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rdata(rdata), .raddr(raddr), .we(we), .waddr(waddr),
    .wdata(wdata), .sda_oe(sda_oe)
  );

  smb_regbank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_bank (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata), .q(reg_q)
  );

endmodule

// File: tb/test_smb_ctl_regs.sv
`timescale 1ns/1ps
module test_smb_ctl_regs;

  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [31:0] reg_q;
  logic        sda_bus;
  int          n_chk = 0;
  int          n_fail = 0;
  int          hi_changes = 0;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  smb_ctl_regs i_smb_ctl_regs (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .reg_q(reg_q)
  );

  // R10 monitor: slave drive changing while SCL is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && scl_m && sda_oe !== oe_prev) hi_changes++;
    oe_prev <= sda_oe;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    b = sda_bus; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic t_reset();
    check("R2 reset register image", reg_q, 32'h00FF_FEFF);
    check("R2 SDA released after reset", {31'd0, sda_oe}, 32'd0);
  endtask

  task automatic t_bad_addr();
    logic a;
    do_start();
    send_byte(8'hA0, a);
    check("R1 foreign address NACKed", {31'd0, a}, 32'd0);
    send_byte(8'h82, a);
    check("R1 bytes after foreign address ignored", {31'd0, a}, 32'd0);
    send_byte(8'h00, a);
    do_stop();
    check("R1 registers untouched", reg_q, 32'h00FF_FEFF);
  endtask

  task automatic t_byte_write();
    logic a;
    do_start();
    send_byte(8'hD2, a);
    check("R1 own address ACKed", {31'd0, a}, 32'd1);
    send_byte(8'h82, a);
    send_byte(8'h5A, a);
    check("R3 single data byte ACKed", {31'd0, a}, 32'd1);
    send_byte(8'h11, a);
    check("R11 second data byte NACKed", {31'd0, a}, 32'd0);
    do_stop();
    check("R3 register 2 written", {24'd0, reg_q[23:16]}, 32'h5A);
    check("R11 second byte not stored", reg_q, 32'h005A_FEFF);
  endtask

  task automatic t_byte_read();
    logic a;
    logic [7:0] v;
    do_start();
    send_byte(8'hD2, a);
    send_byte(8'h82, a);
    do_start();
    send_byte(8'hD3, a);
    recv_byte(1'b0, v);
    do_stop();
    check("R4 read register 2", {24'd0, v}, 32'h5A);
    do_start();
    send_byte(8'hD2, a);
    send_byte(8'h89, a);
    do_start();
    send_byte(8'hD3, a);
    recv_byte(1'b0, v);
    do_stop();
    check("R4 unimplemented index reads zero", {24'd0, v}, 32'h00);
  endtask

  task automatic t_block_write();
    logic a;
    logic [7:0] d [6] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6};
    int acks = 0;
    do_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'd6, a);
    check("R5 byte count ACKed", {31'd0, a}, 32'd1);
    for (int i = 0; i < 6; i++) begin
      send_byte(d[i], a);
      if (a) acks++;
    end
    check("R6 all counted bytes ACKed", acks, 6);
    send_byte(8'h99, a);
    check("R6 byte past count NACKed", {31'd0, a}, 32'd0);
    do_stop();
    check("R5 registers loaded in ascending order", reg_q, 32'hD4C3_B2A1);
  endtask

  task automatic t_block_read();
    logic a;
    logic [7:0] v;
    do_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    do_start();
    send_byte(8'hD3, a);
    recv_byte(1'b1, v);
    check("R7 returned byte count", {24'd0, v}, 32'd4);
    for (int i = 0; i < 4; i++) begin
      recv_byte(1'b1, v);
      check("R7 block read data", {24'd0, v}, {24'd0, reg_q[i*8 +: 8]});
    end
    recv_byte(1'b0, v);
    check("R7 past last register reads zero", {24'd0, v}, 32'h00);
    check("R8 SDA released after master NACK", {31'd0, sda_oe}, 32'd0);
    do_stop();
    check("R8 SDA released after stop", {31'd0, sda_oe}, 32'd0);
  endtask

  task automatic t_abort();
    logic a;
    do_start();
    send_byte(8'hD2, a);
    send_byte(8'h81, a);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    do_stop();
    check("R9 stop mid-byte leaves registers", reg_q, 32'hD4C3_B2A1);
    do_start();
    send_byte(8'hD2, a);
    send_byte(8'h83, a);
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    do_start();
    check("R9 repeated start mid-byte leaves registers", reg_q, 32'hD4C3_B2A1);
    send_byte(8'hD2, a);
    send_byte(8'h83, a);
    send_byte(8'h77, a);
    do_stop();
    check("R9 transfer after abort works", reg_q, 32'h77C3_B2A1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_bad_addr();
    t_byte_write();
    t_byte_read();
    t_block_write();
    t_block_read();
    t_abort();
    check("R10 no drive change while SCL high", hi_changes, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule